// File: doc/BRIEF.md
# Cycle Timer with Compare Interrupt

This block is a free-running cycle counter paired with a compare register. The counter advances on every clock and cannot be stopped. When its value equals a non-zero compare value, the block raises a level interrupt request. That request stays raised until software writes the compare register again.

Software reaches both registers through a single-port register interface. A one-bit select chooses the register, a write enable with write data loads it, and a combinational read port shows the selected value in the same cycle. A configuration input chooses between two behaviours on a match. In the first, the counter restarts from zero, which gives a periodic timer. In the second, the counter runs on, which gives a one-shot alarm on a free-running time base.

Top module: `cycle_timer`

## Requirements
- R1: COUNT rises by exactly one on every clock edge after reset unless software writes COUNT or a match clears it. It wraps from all-ones to zero and raises no flag when it does.
- R2: `rdData` is combinational. It shows COUNT when `regSel` is 0 and COMPARE when `regSel` is 1.
- R3: While `rstN` is low, COUNT and COMPARE are zero and `irqPending` is low.
- R4: A write with `regSel`=0 loads `wrData` into COUNT exactly at that clock edge. The write overrides both the increment and a match clear. A match seen at that edge still sets the pending request.
- R5: A write with `regSel`=1 loads COMPARE and forces `irqPending` low after that edge. This holds even when COUNT equals the old COMPARE at that edge.
- R6: When COMPARE is non-zero and COUNT equals COMPARE at a clock edge, `irqPending` is high after that edge.
- R7: When `autoClearEn`=1, a match makes COUNT zero after that edge. When `autoClearEn`=0, COUNT takes the match value plus one.
- R8: While COMPARE is zero, no match is detected, even when COUNT is zero, and `irqPending` does not rise.
- R9: `irqPending` stays high across later edges, including further matches, until COMPARE is written or reset is applied. COUNT keeps rising while the request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | Register select: 0 = COUNT, 1 = COMPARE |
| wrEn | input | 1 | Write strobe for the selected register |
| wrData | input | WIDTH | Write value |
| autoClearEn | input | 1 | 1 = COUNT restarts at zero on a match |
| rdData | output | WIDTH | Selected register value |
| irqPending | output | 1 | Sticky compare interrupt request |

## Verification
The main function is tried with several patterns. A count that stops short of the compare value shows that no match fires early. Counts that reach the compare value are run with auto-clear on and off, which separates a restart from running on. A run that continues well past a match shows that counting goes on while the request is pending. Compare values at the edges of the range (zero, one and all-ones), combined with counts that wrap through zero, tell a genuine match apart from an accidental match against zero. Directed cases set up a COMPARE write, and separately a COUNT write, in the very cycle of a match, and check which of the two actions wins.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;

  localparam logic SEL_COUNT   = 1'b0;
  localparam logic SEL_COMPARE = 1'b1;

  typedef struct packed {
    logic loadCount;
    logic clearCount;
    logic loadCompare;
  } timerStrobes_t;

endpackage

// File: rtl/cyc_timer_dp.sv
module cyc_timer_dp
  import cyc_timer_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  timerStrobes_t      strb,
  input  logic [WIDTH-1:0]   wrData,
  input  logic               regSel,
  output logic               matchNow,
  output logic [WIDTH-1:0]   compareVal,
  output logic [WIDTH-1:0]   rdData
);

  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

  logic [WIDTH-1:0] countQ;
  logic [WIDTH-1:0] compareQ;

  // Counter: a software load beats a match clear, which beats the increment
  always_ff @(posedge clk) begin
    if (!rstN)                countQ <= ZERO;
    else if (strb.loadCount)  countQ <= wrData;
    else if (strb.clearCount) countQ <= ZERO;
    else                      countQ <= countQ + ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 compareQ <= ZERO;
    else if (strb.loadCompare) compareQ <= wrData;
  end

  // A compare value of zero switches matching off
  assign matchNow   = (compareQ != ZERO) && (countQ == compareQ);
  assign compareVal = compareQ;
  assign rdData     = (regSel == SEL_COMPARE) ? compareQ : countQ;

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadCount && !strb.clearCount) |=> countQ == WIDTH'($past(countQ) + ONE));

  assert_count_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCount |=> countQ == $past(wrData));

  assert_compare_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadCompare |=> $stable(compareQ));

endmodule

// File: rtl/cyc_timer_ctrl.sv
module cyc_timer_ctrl
  import cyc_timer_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          regSel,
  input  logic          autoClearEn,
  input  logic          matchNow,
  output timerStrobes_t strb,
  output logic          irqPending
);

  logic pendingQ;
  logic countWrite;
  logic compareWrite;

  assign countWrite   = wrEn && (regSel == SEL_COUNT);
  assign compareWrite = wrEn && (regSel == SEL_COMPARE);

  always_comb begin
    strb             = '0;
    strb.loadCount   = countWrite;
    strb.clearCount  = matchNow && autoClearEn && !countWrite;
    strb.loadCompare = compareWrite;
  end

  // A COMPARE write clears the request and outranks a match in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN)             pendingQ <= 1'b0;
    else if (compareWrite) pendingQ <= 1'b0;
    else if (matchNow)     pendingQ <= 1'b1;
  end

  assign irqPending = pendingQ;

  assert_clear_on_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    compareWrite |=> !pendingQ);

  assert_set_on_match_R6: assert property (@(posedge clk) disable iff (!rstN)
    (matchNow && !compareWrite) |=> pendingQ);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pendingQ && !compareWrite) |=> pendingQ);

  assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadCount, strb.clearCount}));

endmodule

// File: rtl/cycle_timer.sv
module cycle_timer
  import cyc_timer_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regSel,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             autoClearEn,
  output logic [WIDTH-1:0] rdData,
  output logic             irqPending
);

  timerStrobes_t    strb;
  logic             matchNow;
  logic [WIDTH-1:0] compareVal;

  cyc_timer_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .regSel      (regSel),
    .autoClearEn (autoClearEn),
    .matchNow    (matchNow),
    .strb        (strb),
    .irqPending  (irqPending)
  );

  cyc_timer_dp #(.WIDTH(WIDTH)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (wrData),
    .regSel     (regSel),
    .matchNow   (matchNow),
    .compareVal (compareVal),
    .rdData     (rdData)
  );

  assert_zero_disables_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqPending) |-> $past(compareVal) != '0);

  assert_auto_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (matchNow && autoClearEn && !(wrEn && regSel == SEL_COUNT))
      |=> (regSel != SEL_COUNT) || (rdData == '0));

endmodule

// File: tb/tb_cycle_timer.sv
module tb_cycle_timer;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] cmp;
    logic [31:0] start;
    logic [7:0]  nWait;
    logic        autoClr;
    logic [31:0] expCount;
    logic        expPend;
  } vec_t;

  // cmp, start, waits, autoClr, expCount, expPend
  // After setup COUNT = start+1, COMPARE = cmp, request clear; then nWait edges
  localparam vec_t VECS [9] = '{
    '{32'd10,         32'd4,          8'd3,  1'b1, 32'd8,  1'b0}, // R1 short of match
    '{32'd10,         32'd4,          8'd6,  1'b1, 32'd0,  1'b1}, // R6 R7 restart
    '{32'd10,         32'd4,          8'd6,  1'b0, 32'd11, 1'b1}, // R7 run on
    '{32'd10,         32'd4,          8'd9,  1'b1, 32'd3,  1'b1}, // R9 counts while pending
    '{32'd0,          32'd4,          8'd6,  1'b1, 32'd11, 1'b0}, // R8 disabled
    '{32'd0,          32'hFFFF_FFFE,  8'd2,  1'b1, 32'd1,  1'b0}, // R1 wrap, R8 zero count
    '{32'hFFFF_FFFF,  32'hFFFF_FFFD,  8'd2,  1'b0, 32'd0,  1'b1}, // R6 top value
    '{32'd1,          32'hFFFF_FFFE,  8'd3,  1'b1, 32'd0,  1'b1}, // R6 compare one
    '{32'd20,         32'd4,          8'd16, 1'b0, 32'd21, 1'b1}  // R6 longer run
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regSel = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        autoClearEn = 1'b1;
  logic [31:0] rdData;
  logic        irqPending;

  int checkCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  cycle_timer #(.WIDTH(32)) dut (
    .clk         (clk),
    .rstN        (rstN),
    .regSel      (regSel),
    .wrEn        (wrEn),
    .wrData      (wrData),
    .autoClearEn (autoClearEn),
    .rdData      (rdData),
    .irqPending  (irqPending)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checkCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge with the write taken
  task automatic writeReg(input logic sel, input logic [31:0] val);
    regSel = sel;
    wrData = val;
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic sel, output logic [31:0] val);
    regSel = sel;
    #1;
    val = rdData;
  endtask

  task automatic setup(input logic [31:0] cmp, input logic [31:0] start);
    writeReg(1'b1, 32'd0);
    writeReg(1'b0, start);
    writeReg(1'b1, cmp);
  endtask

  initial begin
    logic [31:0] v;
    @(negedge clk);
    @(negedge clk);
    // R3 values while in reset
    readReg(1'b0, v); check("R3 count in reset", v, 32'd0);
    readReg(1'b1, v); check("R3 compare in reset", v, 32'd0);
    check("R3 pending in reset", {31'd0, irqPending}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    readReg(1'b0, v); check("R1 first increment", v, 32'd1);

    foreach (VECS[i]) begin
      autoClearEn = VECS[i].autoClr;
      setup(VECS[i].cmp, VECS[i].start);
      repeat (int'(VECS[i].nWait)) @(negedge clk);
      readReg(1'b0, v);
      check($sformatf("R1/R6/R7 vector %0d count", i), v, VECS[i].expCount);
      check($sformatf("R6/R8 vector %0d pending", i), {31'd0, irqPending}, {31'd0, VECS[i].expPend});
      readReg(1'b1, v);
      check($sformatf("R2 vector %0d compare readback", i), v, VECS[i].cmp);
    end

    // R9: the request holds and counting continues (COUNT 21, COMPARE 20, no auto-clear)
    repeat (5) @(negedge clk);
    readReg(1'b0, v); check("R9 count keeps rising", v, 32'd26);
    check("R9 request held", {31'd0, irqPending}, 32'd1);
    writeReg(1'b1, 32'd100);
    check("R5 compare write clears request", {31'd0, irqPending}, 32'd0);
    readReg(1'b1, v); check("R2 compare value read", v, 32'd100);

    // R4: exact load
    writeReg(1'b0, 32'hDEAD_BEEF);
    readReg(1'b0, v); check("R4 exact load", v, 32'hDEAD_BEEF);

    // R4: a COUNT write beats the match clear; the match still sets the request
    autoClearEn = 1'b1;
    setup(32'd8, 32'd6);   // COUNT 7 afterwards
    @(negedge clk);        // COUNT 8, equal to COMPARE
    writeReg(1'b0, 32'h55);
    readReg(1'b0, v); check("R4 write beats match clear", v, 32'h55);
    check("R4 match still sets request", {31'd0, irqPending}, 32'd1);

    // R5: a COMPARE write in the match cycle blocks the request
    autoClearEn = 1'b0;
    setup(32'd8, 32'd7);   // COUNT 8 afterwards
    writeReg(1'b1, 32'd8); // match at this edge
    check("R5 write in match cycle blocks request", {31'd0, irqPending}, 32'd0);
    readReg(1'b0, v); check("R7 run on past match", v, 32'd9);

    // R3: a reset applied mid-run clears everything
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    readReg(1'b0, v); check("R3 count after reset", v, 32'd0);
    readReg(1'b1, v); check("R3 compare after reset", v, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

endmodule